// File: doc/BRIEF.md
# Next-PC Unit with Relative Branch Target

This block holds the program counter of a single-cycle processor that fetches 32-bit, word-aligned instructions from a 64-bit address space. On every rising clock edge it loads a new PC. Two dedicated adders run in parallel with the main ALU. One forms the sequential address PC+4. The other adds a scaled branch offset to that incremented value.

The offset comes from the low 16 bits of the current instruction word. It is sign-extended to the address width and multiplied by four, so it reaches an 18-bit byte displacement. A branch-if-not-equal strobe from the decoder selects the target when the ALU reports a non-zero comparison result. In every other case the PC simply advances by four.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the PC is loaded with 0. Reset takes priority over any branch input.
- R2: `pc_plus4` always equals `pc_q + 4` modulo 2^64, so `pc_q = 0xFFFF_FFFF_FFFF_FFFC` gives `pc_plus4 = 0`.
- R3: `br_target` equals `pc_plus4` plus `instr[15:0]`, sign-extended to 64 bits and shifted left by two, modulo 2^64. For example, `instr[15:0] = 0xB123` contributes -80756.
- R4: At a rising edge with reset inactive, `br_ne = 1` and `alu_zero = 0`, the PC loads `br_target`.
- R5: At a rising edge with reset inactive, `br_ne = 1` and `alu_zero = 1`, the PC loads `pc_plus4`.
- R6: At a rising edge with reset inactive and `br_ne = 0`, the PC loads `pc_plus4` whatever the value of `alu_zero`.
- R7: `instr[31:16]` (the opcode and the two register fields) has no effect on `br_target` or on the next PC.
- R8: `pc_q` changes only at a rising clock edge. Input changes between edges leave it unchanged.
- R9: A backward branch from a low address wraps modulo 2^64. With PC 0 and immediate 0x8000, the target is 2^64 - 131068.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 32 | Current instruction word; bits 15:0 hold the branch immediate |
| br_ne | input | 1 | Branch-if-not-equal strobe from the decoder |
| alu_zero | input | 1 | ALU zero flag from the register comparison |
| pc_q | output | 64 | Current program counter |
| pc_plus4 | output | 64 | Sequential address, PC + 4 |
| br_target | output | 64 | PC + 4 plus the scaled, sign-extended offset |

## Verification
The hardest state to reach from the ports is a PC at the very top of the address space, where the sequential adder wraps. Counting up from zero would take about 2^62 cycles. Instead, the stimulus resets the PC to 0 and then takes a branch with immediate 0xFFFE (an offset of -8). This lands the PC at 0xFFFF_FFFF_FFFF_FFFC in one cycle, and the next sequential step then shows `pc_plus4` wrapping to 0. A second backward branch from 0 with the most negative immediate exercises the wrap of the target adder. A reset issued while a taken branch is pending checks the priority of reset.

// File: rtl/pcu_pkg.sv
// Shared constants for the next-PC unit.
// Assumes byte addressing and instructions of a power-of-two byte size.
package pcu_pkg;
    localparam int unsigned PCU_ADDR_W      = 64;
    localparam int unsigned PCU_INSTR_W     = 32;
    localparam int unsigned PCU_IMM_W       = 16;
    localparam int unsigned PCU_INSTR_BYTES = 4;
endpackage

// File: rtl/pcu_step_adder.sv
// Sequential-address adder: adds the fixed instruction size to the PC.
// Assumes the sum wraps modulo 2^ADDR_W; no carry out is kept.
module pcu_step_adder #(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_in,
    output logic [ADDR_W-1:0] pc_next_seq
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    // Dedicated increment, independent of the main ALU.
    always_comb begin
        pc_next_seq = pc_in + STEP;
    end
endmodule

// File: rtl/pcu_offset_gen.sv
// Branch offset generator: sign-extends the immediate field to the
// address width and scales it to a byte displacement.
// Assumes INSTR_BYTES is a power of two, so the scaling is a left shift.
module pcu_offset_gen #(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned IMM_W       = 16,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] byte_off
);
    localparam int unsigned SHIFT = $clog2(INSTR_BYTES);
    localparam int unsigned EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] sext;

    // Replicate the immediate's sign bit into the upper address bits.
    always_comb begin
        sext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end

    // Scale the word offset to a byte offset.
    always_comb begin
        byte_off = sext << SHIFT;
    end
endmodule

// File: rtl/pcu_target_adder.sv
// Branch target adder: adds the scaled offset to the incremented PC.
// Assumes two's-complement operands; the result wraps modulo 2^ADDR_W.
module pcu_target_adder #(
    parameter int unsigned ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] target
);
    // Second dedicated adder, so the ALU stays free for the comparison.
    always_comb begin
        target = base + offset;
    end
endmodule

// File: rtl/next_pc_unit.sv
// Next-PC unit: the PC register, the sequential and branch-target adders,
// and the select between them for a branch-if-not-equal.
// Assumes the immediate sits in the low IMM_W bits of the instruction and
// that alu_zero is low when the compared registers differ.
module next_pc_unit
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W      = PCU_ADDR_W,
    parameter int unsigned INSTR_W     = PCU_INSTR_W,
    parameter int unsigned IMM_W       = PCU_IMM_W,
    parameter int unsigned INSTR_BYTES = PCU_INSTR_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               br_ne,
    input  logic               alu_zero,
    output logic [ADDR_W-1:0]  pc_q,
    output logic [ADDR_W-1:0]  pc_plus4,
    output logic [ADDR_W-1:0]  br_target
);
    localparam logic [ADDR_W-1:0] RESET_PC = '0;

    logic [ADDR_W-1:0] scaled_off;
    logic [ADDR_W-1:0] pc_d;
    logic              take_branch;
    logic              unused_upper_fields;

    // Opcode and register fields are decoded elsewhere.
    assign unused_upper_fields = ^instr[INSTR_W-1:IMM_W];

    pcu_step_adder #(
        .ADDR_W     (ADDR_W),
        .INSTR_BYTES(INSTR_BYTES)
    ) u_step (
        .pc_in      (pc_q),
        .pc_next_seq(pc_plus4)
    );

    pcu_offset_gen #(
        .ADDR_W     (ADDR_W),
        .IMM_W      (IMM_W),
        .INSTR_BYTES(INSTR_BYTES)
    ) u_off (
        .imm     (instr[IMM_W-1:0]),
        .byte_off(scaled_off)
    );

    pcu_target_adder #(
        .ADDR_W(ADDR_W)
    ) u_tgt (
        .base  (pc_plus4),
        .offset(scaled_off),
        .target(br_target)
    );

    // Branch is taken only on inequality: strobe set and zero flag clear.
    always_comb begin
        take_branch = br_ne & ~alu_zero;
        pc_d        = take_branch ? br_target : pc_plus4;
    end

    // PC register: synchronous active-low reset, update on rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end
endmodule

// File: rtl/next_pc_unit_chk.sv
// Property checker for the next-PC unit, attached through bind.
// Assumes it sees the top module's ports unchanged.
module next_pc_unit_chk #(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned IMM_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic               br_ne,
    input logic               alu_zero,
    input logic [ADDR_W-1:0]  pc_q,
    input logic [ADDR_W-1:0]  pc_plus4,
    input logic [ADDR_W-1:0]  br_target
);
    localparam int unsigned EXT_W = ADDR_W - IMM_W - 2;

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0));

    p_seq_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_plus4 - pc_q) == ADDR_W'(4));

    p_target_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_target - pc_plus4) ==
        {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00});

    p_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ne && !alu_zero) |=> (pc_q == $past(br_target)));

    p_equal_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ne && alu_zero) |=> (pc_q == $past(pc_plus4)));

    p_no_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !br_ne |=> (pc_q == $past(pc_plus4)));
endmodule

bind next_pc_unit next_pc_unit_chk #(
    .ADDR_W (ADDR_W),
    .INSTR_W(INSTR_W),
    .IMM_W  (IMM_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (instr),
    .br_ne    (br_ne),
    .alu_zero (alu_zero),
    .pc_q     (pc_q),
    .pc_plus4 (pc_plus4),
    .br_target(br_target)
);

// File: tb/test_next_pc_unit.sv
// Scoreboard bench: the driver applies a cycle and queues the expected
// next PC; the monitor pops it after the edge and compares.
module test_next_pc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        br_ne = 1'b0;
    logic        alu_zero = 1'b0;
    logic [63:0] pc_q, pc_plus4, br_target;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [63:0] exp_q[$];
    logic [63:0] model_pc = '0;
    bit          model_valid = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    next_pc_unit i_next_pc_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr    (instr),
        .br_ne    (br_ne),
        .alu_zero (alu_zero),
        .pc_q     (pc_q),
        .pc_plus4 (pc_plus4),
        .br_target(br_target)
    );

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the outputs between edges, queue the next PC.
    task automatic step(input logic rst, input logic [15:0] imm,
                        input logic br, input logic z, input string req);
        logic [63:0] p4, off, tgt, nxt;
        @(negedge clk);
        rst_n    = ~rst;
        instr    = {$urandom_range(0, 65535)} << 16 | {16'h0, imm};
        br_ne    = br;
        alu_zero = z;
        #1;
        p4  = model_pc + 64'd4;
        off = {{48{imm[15]}}, imm} << 2;
        tgt = p4 + off;
        if (model_valid) begin
            check({"R8 ", req}, pc_q, model_pc);
            check({"R2 ", req}, pc_plus4, p4);
            check({"R3/R7 ", req}, br_target, tgt);
        end
        if (rst)             nxt = '0;
        else if (br && !z)   nxt = tgt;
        else                 nxt = p4;
        exp_q.push_back(nxt);
        model_pc    = nxt;
        model_valid = 1'b1;
    endtask

    // Monitor: after each rising edge, compare pc_q with the queued value.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) check("R1/R4/R5/R6 pc", pc_q, exp_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        step(1'b1, 16'h0000, 1'b0, 1'b0, "R1 reset");
        step(1'b1, 16'h0010, 1'b1, 1'b0, "R1 reset");
        step(1'b0, 16'h0000, 1'b0, 1'b0, "R6 seq");
        step(1'b0, 16'h7FFF, 1'b0, 1'b0, "R6 zero low");
        step(1'b0, 16'h0040, 1'b0, 1'b1, "R6 zero high");
        step(1'b0, 16'h0040, 1'b1, 1'b1, "R5 equal");
        step(1'b0, 16'h0010, 1'b1, 1'b0, "R4 forward");
        step(1'b0, 16'h0003, 1'b1, 1'b0, "R4/R7 forward");
        step(1'b0, 16'hB123, 1'b1, 1'b0, "R4 backward");
        step(1'b0, 16'h0000, 1'b0, 1'b0, "R3 after b123");
        step(1'b1, 16'h1234, 1'b1, 1'b0, "R1 priority");
        step(1'b0, 16'hFFFE, 1'b1, 1'b0, "R9 to top");
        step(1'b0, 16'h0005, 1'b0, 1'b0, "R2 wrap");
        step(1'b0, 16'h8000, 1'b1, 1'b0, "R9 min imm");
        step(1'b0, 16'h8000, 1'b1, 1'b1, "R5 equal");
        for (int k = 0; k < 40; k++)
            step(1'b0, 16'($urandom), 1'($urandom), 1'($urandom), "mixed");
        @(posedge clk);
        #3;
        check("R1 final", 64'(exp_q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule